// File: doc/BRIEF.md
# Interrupt Priority Store with Banked Security View

This block holds one 8-bit priority value for every implemented interrupt and serves register reads and writes to those values. A request can address one priority (byte access) or four neighbouring priorities at once (word access). Every request carries a security attribute. While security is enabled, a non-secure request sees a compressed view of the priorities. Entries whose group bit marks them as secure are hidden from that view. The per-interrupt group bitmap and a global security-disable flag come from elsewhere in the interrupt controller and are inputs here.

Requests are accepted every cycle. A write takes effect at the clock edge that samples it. A read returns its data one cycle later. A two-state response machine sequences the read data. `ST_IDLE` means no read data is being presented. `ST_RESP` means `rsp_valid` is high and `rsp_rdata` holds the data for the read sampled at the previous edge. The machine has four transitions:
- IDLE→RESP on a read request.
- RESP→RESP on back-to-back reads.
- RESP→IDLE when no read is requested.
- IDLE→IDLE otherwise.

A non-secure request is "restricted" when `sec_dis` is low. The interrupt IDs below 32 are internal. Any ID at or above `NUM_IRQ` is unimplemented.

Top module: `irq_prio_regs`

## Requirements
- R1: After reset every stored priority is 0x00 and `rsp_valid` is low.
- R2: A read request produces `rsp_valid` high in the following cycle, with its data on `rsp_rdata`. A write request produces no response in the following cycle.
- R3: A secure request, or any request while `sec_dis` is 1, reads the stored value as-is and stores the written byte as-is.
- R4: A restricted read of a visible entry returns the stored value shifted left by one bit, truncated to 8 bits, so bit 0 of the returned byte is always 0.
- R5: A restricted write to a visible entry stores 0x80 OR'ed with the written byte shifted right by one bit.
- R6: For a restricted request, an entry whose group bit is 0 reads as 0x00, and a write to it leaves the stored value unchanged.
- R7: IDs below 32, and IDs at or above `NUM_IRQ`, always read as 0x00, and writes to them have no effect.
- R8: A word access covers the IDs base..base+3, where base is the address with bits [1:0] cleared. The lowest ID sits in bits [7:0] and the highest in bits [31:24].
- R9: A word write changes nothing at all if base is below 32 or base+3 is at or above `NUM_IRQ`. A word read still returns each in-range lane, with 0x00 in the out-of-range lanes.
- R10: A byte access uses byte lane `addr[1:0]` of `req_wdata` for the write value. Its read data appears in the same lane of `rsp_rdata`, and the other three lanes read 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = four-priority access, 0 = single priority |
| req_secure | input | 1 | Security attribute of the request |
| req_addr | input | ADDR_W | Byte offset into the priority space (equals the interrupt ID) |
| req_wdata | input | 32 | Write data, one priority per byte lane |
| grp_bits | input | NUM_IRQ | Per-interrupt group bit; 0 = secure group |
| sec_dis | input | 1 | Global security-disable flag |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |

## Verification
The bench aims at these corner cases:
- The word at the top of the implemented range, where only two of four IDs exist. A design that checked only the base ID would write the two implemented lanes instead of dropping the whole word.
- Byte accesses that are just out of range on either side, at ID 31 and at `NUM_IRQ`. An off-by-one range test would store into those entries or return them.
- Restricted accesses to group-0 entries, including writes. Dropping the hiding lets a non-secure write change a secure priority.
- Stored values with the top bit set. A wrong shift direction or a missing 0x80 forcing shows up as a mismatch between the secure view and the non-secure view of the same entry.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    localparam int PRIO_W = 8;
    localparam int LANES  = 4;

    typedef logic [PRIO_W-1:0] prio_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } resp_state_e;

endpackage

// File: rtl/irq_prio_lane.sv
module irq_prio_lane
    import irq_prio_pkg::*;
#(
    parameter int NUM_IRQ   = 62,
    parameter int ADDR_W    = 10,
    parameter int FIRST_EXT = 32,
    localparam int IDX_W    = $clog2(NUM_IRQ),
    localparam int SPAN     = 1 << IDX_W
) (
    input  logic [ADDR_W-1:0]  lane_id,
    input  logic               lane_sel,
    input  logic               is_word,
    input  logic               word_ok,
    input  logic               wr,
    input  logic               restricted,
    input  logic [NUM_IRQ-1:0] grp_bits,
    input  prio_t              stored,
    input  prio_t              wbyte,
    output logic [IDX_W-1:0]   idx,
    output logic               wen,
    output prio_t              wval,
    output prio_t              rval
);
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(FIRST_EXT);
    localparam logic [ADDR_W-1:0] HI = ADDR_W'(NUM_IRQ);

    logic            in_range;
    logic            hidden;
    logic [SPAN-1:0] grp_pad;

    always_comb begin
        grp_pad  = SPAN'(grp_bits);
        in_range = (lane_id >= LO) && (lane_id < HI);
        idx      = lane_id[IDX_W-1:0];
        hidden   = restricted && !(in_range && grp_pad[idx]);

        if (!lane_sel || !in_range || hidden)
            rval = '0;
        else if (restricted)
            rval = {stored[PRIO_W-2:0], 1'b0};
        else
            rval = stored;

        wval = restricted ? (prio_t'(8'h80) | (wbyte >> 1)) : wbyte;
        wen  = wr && lane_sel && in_range && !hidden && (!is_word || word_ok);
    end

endmodule

// File: rtl/irq_prio_store.sv
module irq_prio_store
    import irq_prio_pkg::*;
#(
    parameter int NUM_IRQ   = 62,
    parameter int FIRST_EXT = 32,
    localparam int IDX_W    = $clog2(NUM_IRQ)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [LANES-1:0][IDX_W-1:0] idx,
    input  logic [LANES-1:0]            wen,
    input  prio_t [LANES-1:0]           wval,
    output prio_t [LANES-1:0]           rval
);
    prio_t entry [NUM_IRQ];

    for (genvar e = 0; e < NUM_IRQ; e++) begin : g_entry
        if (e < FIRST_EXT) begin : g_internal
            assign entry[e] = '0;
        end else begin : g_ext
            logic  hit;
            prio_t nxt;
            always_comb begin
                hit = 1'b0;
                nxt = '0;
                for (int l = 0; l < LANES; l++) begin
                    if (wen[l] && (idx[l] == IDX_W'(e))) begin
                        hit = 1'b1;
                        nxt = wval[l];
                    end
                end
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)   entry[e] <= '0;
                else if (hit) entry[e] <= nxt;
            end
        end
    end

    always_comb begin
        for (int l = 0; l < LANES; l++)
            rval[l] = (int'(idx[l]) < NUM_IRQ) ? entry[idx[l]] : '0;
    end

endmodule

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
    import irq_prio_pkg::*;
#(
    parameter int NUM_IRQ   = 62,
    parameter int ADDR_W    = 10,
    parameter int FIRST_EXT = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_word,
    input  logic               req_secure,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [31:0]        req_wdata,
    input  logic [NUM_IRQ-1:0] grp_bits,
    input  logic               sec_dis,
    output logic               rsp_valid,
    output logic [31:0]        rsp_rdata
);
    localparam int IDX_W = $clog2(NUM_IRQ);
    localparam logic [ADDR_W-1:0] LO = ADDR_W'(FIRST_EXT);
    localparam logic [ADDR_W:0]   HI = (ADDR_W+1)'(NUM_IRQ);

    resp_state_e state_q, state_d;

    logic                        restricted, wr, rd_req, word_ok;
    logic [ADDR_W-1:0]           base;
    logic [LANES-1:0][IDX_W-1:0] idx;
    logic [LANES-1:0]            wen;
    prio_t [LANES-1:0]           wval, stored, rval;
    logic [31:0]                 rdata_c;

    always_comb begin
        restricted = !req_secure && !sec_dis;
        wr         = req_valid && req_write;
        rd_req     = req_valid && !req_write;
        base       = {req_addr[ADDR_W-1:2], 2'b00};
        word_ok    = (base >= LO) && (({1'b0, base} + (ADDR_W+1)'(3)) < HI);
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [ADDR_W-1:0] lane_id;
        logic              lane_sel;
        assign lane_id  = req_word ? (base | ADDR_W'(k)) : req_addr;
        assign lane_sel = req_word || (req_addr[1:0] == 2'(k));
        assign rdata_c[8*k +: 8] = rval[k];

        irq_prio_lane #(
            .NUM_IRQ   (NUM_IRQ),
            .ADDR_W    (ADDR_W),
            .FIRST_EXT (FIRST_EXT)
        ) u_lane (
            .lane_id    (lane_id),
            .lane_sel   (lane_sel),
            .is_word    (req_word),
            .word_ok    (word_ok),
            .wr         (wr),
            .restricted (restricted),
            .grp_bits   (grp_bits),
            .stored     (stored[k]),
            .wbyte      (req_wdata[8*k +: 8]),
            .idx        (idx[k]),
            .wen        (wen[k]),
            .wval       (wval[k]),
            .rval       (rval[k])
        );
    end

    irq_prio_store #(
        .NUM_IRQ   (NUM_IRQ),
        .FIRST_EXT (FIRST_EXT)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .idx   (idx),
        .wen   (wen),
        .wval  (wval),
        .rval  (stored)
    );

    // Response sequencing: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = rd_req ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_req ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Response sequencing: outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rsp_rdata <= '0;
        else if (rd_req) rsp_rdata <= rdata_c;
        else             rsp_rdata <= '0;
    end

    assign rsp_valid = (state_q == ST_RESP);

    // R2
    read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rsp_valid);

    // R2
    write_no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> !rsp_valid);

    // R7
    oor_byte_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !req_word &&
         ((req_addr < LO) || ({1'b0, req_addr} >= HI))) |=> (rsp_rdata == 32'h0));

    // R6
    hidden_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !req_word && !req_secure && !sec_dis &&
         (req_addr >= LO) && ({1'b0, req_addr} < HI) &&
         !grp_bits[req_addr[IDX_W-1:0]]) |=> (rsp_rdata == 32'h0));

    // R4
    ns_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !req_word && !req_secure && !sec_dis)
        |=> (rsp_rdata[{$past(req_addr[1:0]), 3'b000}] == 1'b0));

endmodule

// File: tb/irq_prio_regs_tb.sv
module irq_prio_regs_tb;
    localparam int NUM     = 62;
    localparam int AW      = 10;
    localparam int CLK_PER = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0, req_write = 1'b0, req_word = 1'b0, req_secure = 1'b0;
    logic [AW-1:0]  req_addr = '0;
    logic [31:0]    req_wdata = '0;
    logic [NUM-1:0] grp_bits = '0;
    logic           sec_dis = 1'b0;
    logic           rsp_valid;
    logic [31:0]    rsp_rdata;

    int errors = 0;
    int checks = 0;
    int model [NUM];

    always #(CLK_PER/2) clk = ~clk;

    irq_prio_regs #(.NUM_IRQ(NUM), .ADDR_W(AW), .FIRST_EXT(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_word(req_word), .req_secure(req_secure), .req_addr(req_addr),
        .req_wdata(req_wdata), .grp_bits(grp_bits), .sec_dis(sec_dis),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata));

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    function automatic bit visible(int id, bit sec);
        return (sec || sec_dis || grp_bits[id]);
    endfunction

    function automatic logic [31:0] exp_read(bit sec, bit word, int addr);
        logic [31:0] r = '0;
        for (int k = 0; k < 4; k++) begin
            int id = word ? ((addr & ~3) + k) : addr;
            bit sel = word || ((addr & 3) == k);
            if (sel && id >= 32 && id < NUM && visible(id, sec))
                r[8*k +: 8] = (!sec && !sec_dis) ? 8'((model[id] << 1) & 255) : 8'(model[id]);
        end
        return r;
    endfunction

    function automatic void apply_write(bit sec, bit word, int addr, logic [31:0] d);
        int b = addr & ~3;
        if (word && (b < 32 || b + 3 >= NUM)) return;
        for (int k = 0; k < 4; k++) begin
            int id = word ? (b + k) : addr;
            bit sel = word || ((addr & 3) == k);
            if (sel && id >= 32 && id < NUM && visible(id, sec))
                model[id] = (!sec && !sec_dis) ? (32'h80 | (int'(d[8*k +: 8]) >> 1)) : int'(d[8*k +: 8]);
        end
    endfunction

    task automatic access(string req, bit wr, bit word, bit sec, int addr, logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_word = word; req_secure = sec;
        req_addr = AW'(addr); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (wr) begin
            check({req, " R2 no response"}, {31'b0, rsp_valid}, 32'h0);
            apply_write(sec, word, addr, d);
        end else begin
            check({req, " R2 valid"}, {31'b0, rsp_valid}, 32'h1);
            check(req, rsp_rdata, exp_read(sec, word, addr));
        end
    endtask

    initial begin
        #(CLK_PER * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NUM; i++) model[i] = 0;
        grp_bits = '1;
        repeat (3) @(negedge clk);
        check("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
        rst_n = 1'b1;
        for (int a = 32; a < NUM; a += 4) access("R1 reset priorities", 0, 1, 1, a, 0);

        // R3 secure and disabled paths keep values unchanged
        access("R3 secure write", 1, 0, 1, 33, 32'h0000_F100);
        access("R3 secure read", 0, 0, 1, 33, 0);
        sec_dis = 1'b1;
        access("R3 disabled ns write", 1, 0, 0, 34, 32'h00C3_0000);
        access("R3 disabled ns read", 0, 0, 0, 34, 0);
        sec_dis = 1'b0;
        // R5 and R4 views
        access("R5 ns write", 1, 0, 0, 40, 32'h0000_0040);
        access("R5 secure sees forced top bit", 0, 0, 1, 40, 0);
        access("R4 ns read shifted", 0, 0, 0, 40, 0);
        access("R4 setup", 1, 0, 1, 44, 32'h0000_00FF);
        access("R4 ns read truncates", 0, 0, 0, 44, 0);
        // R6 hidden entries
        access("R6 setup", 1, 0, 1, 41, 32'h0000_3300);
        grp_bits[41] = 1'b0;
        access("R6 ns write ignored", 1, 0, 0, 41, 32'h0000_1100);
        access("R6 ns read zero", 0, 0, 0, 41, 0);
        access("R6 secure value kept", 0, 0, 1, 41, 0);
        // R7 range edges
        access("R7 write id 31", 1, 0, 1, 31, 32'hAA00_0000);
        access("R7 read id 31", 0, 0, 1, 31, 0);
        access("R7 write id NUM", 1, 0, 1, NUM, 32'h0000_BB00);
        access("R7 read id NUM", 0, 0, 1, NUM, 0);
        access("R7 read internal word", 0, 1, 1, 28, 0);
        // R9 partial top word
        access("R9 partial word write dropped", 1, 1, 1, 60, 32'h1122_3344);
        access("R9 partial word read", 0, 1, 1, 60, 0);
        access("R9 byte write id 61", 1, 0, 1, 61, 32'h0000_7700);
        access("R9 partial word read after byte", 0, 1, 1, 60, 0);
        // R8 and R10 lane placement
        access("R8 word write", 1, 1, 1, 48, 32'hD4C3_B2A1);
        access("R8 word read", 0, 1, 1, 48, 0);
        access("R10 byte lane 2", 0, 0, 1, 50, 0);
        access("R10 byte lane 3 write", 1, 0, 1, 51, 32'h5E00_0000);
        access("R10 byte lane 3 read", 0, 1, 1, 48, 0);

        // Random mix over all requirements
        for (int i = 0; i < 1500; i++) begin
            int a;
            if (i % 60 == 0) grp_bits = {$urandom, $urandom};
            sec_dis = ($urandom % 5 == 0);
            a = ($urandom % 16 == 0) ? int'($urandom % 1024) : int'($urandom % 68);
            access("R3/R4/R5/R6/R7/R8 random", $urandom % 2, $urandom % 2,
                   $urandom % 2, a, $urandom);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule